// File: doc/BRIEF.md
# Weighted Document Relevance Scorer

This block turns a stream of packed word entries into one relevance score per document. Each entry is 32 bits: the upper 24 bits carry a word identifier and the lower 8 bits carry how often that word occurs in the document. Alongside each entry comes a one-bit membership flag from an earlier filtering stage. For each flagged entry, the block reads a 32-bit weight from an external weight memory, using the word identifier as the address. It multiplies that weight by the occurrence count and adds the product to the score of the current document.

Documents are framed by a separate length channel. A length word tells the block how many entries the next document spans. The block accepts exactly that many entries and then presents the final 64-bit score, together with a running document index, on a valid/ready output. While that result waits to be taken, the block accepts neither entries nor lengths. The weight memory is a plain synchronous RAM with a fixed one-cycle read latency. Because reads are issued only for flagged entries, the read addresses follow the data and are not sequential.

The control is a four-state machine. In IDLE it waits for a length. The START transition goes to RUN when the length is non-zero, and the EMPTY transition goes straight to EMIT when the length is zero. In RUN it accepts one entry per cycle. After the final entry, the LAST transition goes to TAIL, where the last weight read lands in the accumulator. The SETTLE transition then goes to EMIT. In EMIT the score is offered, and the SENT transition returns to IDLE once the score is taken. SENT also clears the score and advances the document index.

Top module: `doc_relevance_scorer`

## Requirements
- R1: The read address presented with a flagged entry equals bits 31:8 of that entry (the word identifier); bits 7:0 are the occurrence count used as the multiplier.
- R2: A weight read (`wt_rd_en` high) is issued in exactly the cycles where an entry with flag 1 is accepted; an entry with flag 0 issues no read and adds nothing to the score.
- R3: The emitted score is the sum, over the flagged entries of the document, of weight times occurrence count, held as a 64-bit unsigned value with no truncation (a document of 300 entries with weight 0xFFFFFFFF and count 255 must come out exact).
- R4: After a length N > 0 is accepted, exactly N entries are accepted. The score appears on the output two cycles after the last of them is accepted. Lengths and entries are never both accepted in the same cycle, and after a score is taken the block returns to waiting for a length.
- R5: A document of length 0 emits a score of 0 in the cycle after its length is accepted.
- R6: While `out_valid` is high and `out_ready` is low, the score and the document index stay unchanged, and neither `ent_ready` nor `len_ready` is high.
- R7: The document index is 0 after reset and rises by exactly one for each score taken.
- R8: During and right after reset, `out_valid`, `ent_ready` and `wt_rd_en` are low, `len_ready` is high and the score reads 0.
- R9: While a document is in progress and entries are offered every cycle, one entry is accepted in every cycle, with no stall between entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_valid | input | 1 | Document length offered |
| len_ready | output | 1 | Block can accept a document length |
| len_count | input | CNT_W (16) | Number of entries in the next document |
| ent_valid | input | 1 | Entry offered |
| ent_ready | output | 1 | Block can accept an entry |
| ent_word | input | ENTRY_W (32) | Packed entry: word identifier above, occurrence count in the low FREQ_W bits |
| ent_hit | input | 1 | Membership flag of the entry |
| wt_rd_en | output | 1 | Weight memory read strobe |
| wt_rd_addr | output | ID_W (24) | Weight memory read address (word identifier) |
| wt_rd_data | input | WT_W (32) | Weight returned one cycle after the strobe |
| out_valid | output | 1 | Document score available |
| out_ready | input | 1 | Consumer takes the score |
| out_doc | output | DOC_W (16) | Index of the document being reported |
| out_score | output | ACC_W (64) | Final score of that document |

## Verification
The scorer is driven with documents of all-flagged entries sent back to back. This checks the multiply-accumulate and the one-entry-per-cycle rate. Documents with mixed flags and idle gaps between entries show whether unflagged entries are skipped and whether the delayed weight stays aligned with its count when the input stutters. A long document of maximum weights and counts separates a 64-bit sum from a truncated one. Zero-length documents and a consumer that holds off the output at pseudo-random cycles exercise the EMPTY path, the hold of the score and index, and the input stall while the result is pending.

// File: rtl/doc_relevance_scorer_pkg.sv
package doc_relevance_scorer_pkg;

    // Control states of the per-document sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a document length
        ST_RUN  = 2'd1,   // accepting entries
        ST_TAIL = 2'd2,   // last weight read landing in the accumulator
        ST_EMIT = 2'd3    // final score offered on the output
    } scr_state_e;

endpackage

// File: rtl/rs_entry_split.sv
// Splits a packed entry into identifier and count, and raises the weight read
// strobe only for flagged entries that are accepted this cycle.
module rs_entry_split #(
    parameter int ENTRY_W = 32,
    parameter int FREQ_W  = 8,
    localparam int ID_W   = ENTRY_W - FREQ_W
) (
    input  logic [ENTRY_W-1:0] word,
    input  logic               hit,
    input  logic               take,
    output logic [ID_W-1:0]    id,
    output logic [FREQ_W-1:0]  freq,
    output logic               rd_en
);
    always_comb begin
        id    = word[ENTRY_W-1:FREQ_W];
        freq  = word[FREQ_W-1:0];
        rd_en = take & hit;
    end
endmodule

// File: rtl/rs_align.sv
// Delays the "contributes" marker and the count by the weight memory latency,
// so both meet the returned weight in the same cycle.
module rs_align #(
    parameter int FREQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_in,
    input  logic [FREQ_W-1:0] freq_in,
    output logic              use_q,
    output logic [FREQ_W-1:0] freq_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_q  <= 1'b0;
            freq_q <= '0;
        end else begin
            use_q  <= use_in;
            freq_q <= freq_in;
        end
    end
endmodule

// File: rtl/rs_mac.sv
// Multiply-accumulate of weight times count into a wide unsigned score.
module rs_mac #(
    parameter int WT_W   = 32,
    parameter int FREQ_W = 8,
    parameter int ACC_W  = 64,
    localparam int PROD_W = WT_W + FREQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [WT_W-1:0]   weight,
    input  logic [FREQ_W-1:0] freq,
    output logic [ACC_W-1:0]  acc
);
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(weight) * PROD_W'(freq);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= acc + ACC_W'(prod);
        end
    end
endmodule

// File: rtl/rs_doc_fsm.sv
// Per-document sequencer: takes a length, counts entries, waits for the last
// product, then offers the score until the consumer takes it.
module rs_doc_fsm
    import doc_relevance_scorer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DOC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_valid,
    input  logic [CNT_W-1:0] len_count,
    input  logic             ent_valid,
    input  logic             out_ready,
    output logic             len_ready,
    output logic             ent_ready,
    output logic             ent_take,
    output logic             out_valid,
    output logic             out_clr,
    output logic [DOC_W-1:0] doc_idx
);
    scr_state_e       state, state_nx;
    logic [CNT_W-1:0] remain;
    logic             len_take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: START, EMPTY, LAST, SETTLE, SENT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (len_valid) begin
                    state_nx = (len_count == '0) ? ST_EMIT : ST_RUN;
                end
            end
            ST_RUN: begin
                if (ent_valid && remain == CNT_W'(1)) begin
                    state_nx = ST_TAIL;
                end
            end
            ST_TAIL: state_nx = ST_EMIT;
            ST_EMIT: begin
                if (out_ready) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        len_ready = 1'b0;
        ent_ready = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_IDLE: len_ready = 1'b1;
            ST_RUN:  ent_ready = 1'b1;
            ST_TAIL: ;
            ST_EMIT: out_valid = 1'b1;
            default: ;
        endcase
        len_take = len_ready & len_valid;
        ent_take = ent_ready & ent_valid;
        out_clr  = out_valid & out_ready;
    end

    // entry countdown and document index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            doc_idx <= '0;
        end else begin
            if (len_take) begin
                remain <= len_count;
            end else if (ent_take) begin
                remain <= remain - CNT_W'(1);
            end
            if (out_clr) begin
                doc_idx <= doc_idx + DOC_W'(1);
            end
        end
    end
endmodule

// File: rtl/doc_relevance_scorer.sv
module doc_relevance_scorer #(
    parameter int ENTRY_W = 32,
    parameter int FREQ_W  = 8,
    parameter int WT_W    = 32,
    parameter int ACC_W   = 64,
    parameter int CNT_W   = 16,
    parameter int DOC_W   = 16,
    localparam int ID_W   = ENTRY_W - FREQ_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               len_valid,
    output logic               len_ready,
    input  logic [CNT_W-1:0]   len_count,
    input  logic               ent_valid,
    output logic               ent_ready,
    input  logic [ENTRY_W-1:0] ent_word,
    input  logic               ent_hit,
    output logic               wt_rd_en,
    output logic [ID_W-1:0]    wt_rd_addr,
    input  logic [WT_W-1:0]    wt_rd_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DOC_W-1:0]   out_doc,
    output logic [ACC_W-1:0]   out_score
);
    logic              ent_take;
    logic              out_clr;
    logic [FREQ_W-1:0] freq_now;
    logic              use_q;
    logic [FREQ_W-1:0] freq_q;

    rs_doc_fsm #(
        .CNT_W (CNT_W),
        .DOC_W (DOC_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_valid (len_valid),
        .len_count (len_count),
        .ent_valid (ent_valid),
        .out_ready (out_ready),
        .len_ready (len_ready),
        .ent_ready (ent_ready),
        .ent_take  (ent_take),
        .out_valid (out_valid),
        .out_clr   (out_clr),
        .doc_idx   (out_doc)
    );

    rs_entry_split #(
        .ENTRY_W (ENTRY_W),
        .FREQ_W  (FREQ_W)
    ) u_split (
        .word  (ent_word),
        .hit   (ent_hit),
        .take  (ent_take),
        .id    (wt_rd_addr),
        .freq  (freq_now),
        .rd_en (wt_rd_en)
    );

    rs_align #(
        .FREQ_W (FREQ_W)
    ) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_in  (wt_rd_en),
        .freq_in (freq_now),
        .use_q   (use_q),
        .freq_q  (freq_q)
    );

    rs_mac #(
        .WT_W   (WT_W),
        .FREQ_W (FREQ_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (out_clr),
        .add_en (use_q),
        .weight (wt_rd_data),
        .freq   (freq_q),
        .acc    (out_score)
    );
endmodule

// File: rtl/doc_relevance_scorer_chk.sv
module doc_relevance_scorer_chk #(
    parameter int ID_W  = 24,
    parameter int ACC_W = 64,
    parameter int DOC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             len_ready,
    input logic             ent_valid,
    input logic             ent_ready,
    input logic             ent_hit,
    input logic [ID_W-1:0]  ent_id,
    input logic             wt_rd_en,
    input logic [ID_W-1:0]  wt_rd_addr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DOC_W-1:0] out_doc,
    input logic [ACC_W-1:0] out_score
);
    assert_rd_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wt_rd_en |-> (ent_valid && ent_ready && ent_hit));

    assert_rd_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && ent_ready && ent_hit) |-> wt_rd_en);

    assert_rd_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wt_rd_en |-> (wt_rd_addr == ent_id));

    assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_score) && $stable(out_doc)));

    assert_input_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!ent_ready && !len_ready));

    assert_doc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (out_doc == $past(out_doc) + DOC_W'(1)));

    assert_back_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && len_ready));

    assert_excl_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ent_ready && len_ready));
endmodule

bind doc_relevance_scorer doc_relevance_scorer_chk #(
    .ID_W  (ID_W),
    .ACC_W (ACC_W),
    .DOC_W (DOC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .len_ready  (len_ready),
    .ent_valid  (ent_valid),
    .ent_ready  (ent_ready),
    .ent_hit    (ent_hit),
    .ent_id     (ent_word[ENTRY_W-1:FREQ_W]),
    .wt_rd_en   (wt_rd_en),
    .wt_rd_addr (wt_rd_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_doc    (out_doc),
    .out_score  (out_score)
);

// File: tb/doc_relevance_scorer_test.sv
module doc_relevance_scorer_test;
    localparam int CNT_W  = 16;
    localparam int DOC_W  = 16;
    localparam int N_DOCS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        len_valid;
    logic        len_ready;
    logic [15:0] len_count;
    logic        ent_valid;
    logic        ent_ready;
    logic [31:0] ent_word;
    logic        ent_hit;
    logic        wt_rd_en;
    logic [23:0] wt_rd_addr;
    logic [31:0] wt_rd_data;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_doc;
    logic [63:0] out_score;

    int checks = 0;
    int fails  = 0;
    int docs_done = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    doc_relevance_scorer uut (
        .clk(clk), .rst_n(rst_n),
        .len_valid(len_valid), .len_ready(len_ready), .len_count(len_count),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_word(ent_word), .ent_hit(ent_hit),
        .wt_rd_en(wt_rd_en), .wt_rd_addr(wt_rd_addr), .wt_rd_data(wt_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_doc(out_doc), .out_score(out_score)
    );

    function automatic logic [31:0] wfun(input logic [23:0] id);
        if (id == 24'hFFFFFF) return 32'hFFFF_FFFF;
        return ({8'd0, id} * 32'd2654435761) ^ 32'h1357_9BDF;
    endfunction

    // synchronous weight RAM, one-cycle read latency
    always @(posedge clk) begin
        if (wt_rd_en) wt_rd_data <= wfun(wt_rd_addr);
    end

    task automatic chk_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    // consumer readiness: always ready, or pseudo-random back-pressure
    logic [15:0] lfsr = 16'hACE1;
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_mode ? lfsr[2] : 1'b1;
        end
    end

    // cycle-by-cycle reference model: 0 wait-length, 1 taking entries,
    // 2 last product landing, 3 result offered
    int          m_phase = 0;
    int          m_rem = 0;
    bit          m_zero = 1'b0;
    logic [63:0] m_sum = '0;
    logic [15:0] m_doc = '0;

    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            #2;
            chk_eq("R4", "len_ready", {63'd0, len_ready}, {63'd0, m_phase == 0});
            chk_eq("R9", "ent_ready", {63'd0, ent_ready}, {63'd0, m_phase == 1});
            chk_eq("R4", "out_valid", {63'd0, out_valid}, {63'd0, m_phase == 3});
            chk_eq("R2", "wt_rd_en", {63'd0, wt_rd_en},
                   {63'd0, ent_valid && ent_ready && ent_hit});
            if (wt_rd_en)
                chk_eq("R1", "wt_rd_addr", {40'd0, wt_rd_addr}, {40'd0, ent_word[31:8]});
            if (m_phase == 3) begin
                chk_eq(m_zero ? "R5" : "R3", "out_score", out_score, m_sum);
                chk_eq("R7", "out_doc", {48'd0, out_doc}, {48'd0, m_doc});
            end
            unique case (m_phase)
                0: if (len_valid && len_ready) begin
                       m_sum = '0;
                       m_zero = (len_count == 0);
                       m_rem = int'(len_count);
                       m_phase = m_zero ? 3 : 1;
                   end
                1: if (ent_valid && ent_ready) begin
                       if (ent_hit)
                           m_sum = m_sum + 64'(wfun(ent_word[31:8])) * 64'(ent_word[7:0]);
                       m_rem--;
                       if (m_rem == 0) m_phase = 2;
                   end
                2: m_phase = 3;
                3: if (out_ready) begin
                       m_phase = 0;
                       m_doc = m_doc + 16'd1;
                       docs_done++;
                   end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic send_len(input int n);
        len_valid = 1'b1;
        len_count = 16'(n);
        #1;
        while (!len_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        len_valid = 1'b0;
    endtask

    task automatic send_ent(input logic [23:0] id, input logic [7:0] fq, input logic hit);
        ent_valid = 1'b1;
        ent_word  = {id, fq};
        ent_hit   = hit;
        #1;
        while (!ent_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        ent_valid = 1'b0;
        ent_hit   = 1'b0;
    endtask

    // kind 0: all flagged; kind 1: mixed flags; kind 2: maximum weight and count
    task automatic run_doc(input int n, input int kind, input bit gap);
        send_len(n);
        for (int k = 0; k < n; k++) begin
            unique case (kind)
                0: send_ent(24'(k * 977 + 13), 8'(k + 1), 1'b1);
                1: send_ent(24'(k * 40503 + 7), 8'(k * 29 + 3), (k % 3) != 1);
                default: send_ent(24'hFFFFFF, 8'hFF, 1'b1);
            endcase
            if (gap && (k % 2 == 0)) @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        rst_n = 1'b0;
        len_valid = 1'b0; len_count = '0;
        ent_valid = 1'b0; ent_word = '0; ent_hit = 1'b0;
        repeat (5) @(negedge clk);
        chk_eq("R8", "out_valid in reset", {63'd0, out_valid}, 64'd0);
        chk_eq("R8", "ent_ready in reset", {63'd0, ent_ready}, 64'd0);
        chk_eq("R8", "wt_rd_en in reset", {63'd0, wt_rd_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R8", "len_ready after reset", {63'd0, len_ready}, 64'd1);
        chk_eq("R8", "out_score after reset", out_score, 64'd0);
        chk_eq("R7", "out_doc after reset", {48'd0, out_doc}, 64'd0);

        run_doc(4, 0, 1'b0);     // back-to-back, all flagged (R3, R9)
        run_doc(0, 0, 1'b0);     // empty document (R5)
        run_doc(6, 1, 1'b1);     // mixed flags with gaps (R2)
        run_doc(300, 2, 1'b0);   // wide sum (R3)
        run_doc(0, 0, 1'b0);     // empty document (R5)
        bp_mode = 1'b1;          // back-pressure from here on (R6)
        run_doc(5, 1, 1'b0);
        run_doc(1, 0, 1'b0);
        run_doc(0, 0, 1'b0);
        run_doc(7, 1, 1'b1);
        run_doc(3, 0, 1'b0);

        for (int w = 0; w < 200 && docs_done < N_DOCS; w++) @(negedge clk);
        chk_eq("R4", "documents emitted", 64'(docs_done), 64'(N_DOCS));
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R4 watchdog: documents emitted actual=%0d expected=%0d",
                     docs_done, N_DOCS);
            summary();
            $finish;
        end
    end
endmodule